// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a 16-bit down-counter that raises a level interrupt each time it passes its terminal count. The counter advances on a tick derived from the core clock: the clock is halved and then divided by a power of two chosen by a 4-bit prescale field, giving one tick every 2^(PRE+1) clock cycles. At the terminal point the counter either reloads from a software-written modulus (reload mode) or restarts from 0xFFFF (free-running mode).

Software reaches the timer through three 16-bit registers at byte offsets 0 (control/status), 2 (modulus) and 4 (live count, read-only). Accesses are plain strobes with no back-pressure. The block accepts a write or a read on every cycle it is offered. Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read. Writes take effect at the clock edge that samples `wr_en`. Each register is one 16-bit word with bit 15 as the most significant bit, so byte order is settled by the bus fabric outside the block.

Control/status fields, by bit: 0 run, 1 reload mode, 2 terminal flag, 3 interrupt enable, 4 overwrite, 5 and 6 stored-only spare control bits, 11:8 prescale. All other bits read zero.

Top module: `pit_timer`

## Requirements
- R1: After reset the control/status and modulus registers read 0x0000, the count register reads 0xFFFF and `irq` is low.
- R2: While the run bit (bit 0) is 1, the counter decrements once every 2^(PRE+1) clock cycles, where PRE is bits 11:8. The first decrement after a restart comes one full period after it.
- R3: With reload mode (bit 1) set, a tick that finds the count at 0 loads the modulus value and sets the flag (bit 2).
- R4: With reload mode clear, a tick that finds the count at 0 loads 0xFFFF and sets the flag.
- R5: `irq` is high exactly while the flag (bit 2) and the interrupt enable (bit 3) are both 1.
- R6: Writing a control word with bit 2 set clears the flag. With bit 2 clear, the flag keeps its value. A terminal event in the same cycle wins and leaves the flag set.
- R7: A control write that differs from the stored value only in bits 2 and 3 leaves the count and the prescale phase untouched.
- R8: A control write that changes any other writable bit clears the prescale phase and loads the counter with the new wrap limit. This is the modulus if the written bit 1 is 1, otherwise 0xFFFF. Counting then continues only if the written bit 0 is 1.
- R9: A write to the modulus register (offset 2) clears the flag, unless a terminal event occurs in the same cycle.
- R10: A modulus write while overwrite (bit 4) is set loads the written value into the counter at once. With overwrite clear, the counter is left alone.
- R11: Writes to offset 4 and to any offset other than 0 and 2 change no register. Reads from offsets other than 0, 2 and 4 return 0.
- R12: While the run bit is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt request |

## Verification
The checker watches four rules on every cycle:
- the count holds while the timer is stopped;
- the count steps down by at most one per cycle between terminal events;
- the flag is set after each terminal event and in free-running mode the count lands on 0xFFFF;
- a modulus write clears the flag, an interrupt can only fall after a write, and writes to the count or unknown offsets leave the registers alone.

The exact tick period, the reload value, the enable-only write that keeps the count running, and the restart with a new wrap limit can only be shown by the bench. It compares every read and the interrupt line against a reference model, under directed and random register traffic.

// File: rtl/pit_pkg.sv
package pit_pkg;
  // Byte offsets of the registers.
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_MOD  = 2;
  localparam int unsigned OFS_CNT  = 4;

  // Control/status bit positions.
  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_RLD   = 1;
  localparam int unsigned B_FLAG  = 2;
  localparam int unsigned B_IE    = 3;
  localparam int unsigned B_OVW   = 4;
  localparam int unsigned B_SPR0  = 5;
  localparam int unsigned B_SPR1  = 6;
  localparam int unsigned PRE_LSB = 8;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              wrap,
  output logic [CNT_W-1:0]  ctrl_q,
  output logic [CNT_W-1:0]  mod_q,
  output logic              restart,
  output logic              ovw_load
);
  localparam logic [CNT_W-1:0] PRE_MASK = CNT_W'(((1 << PRE_W) - 1) << PRE_LSB);
  localparam logic [CNT_W-1:0] BIT_MASK = CNT_W'((1 << B_RUN) | (1 << B_RLD) |
      (1 << B_FLAG) | (1 << B_IE) | (1 << B_OVW) | (1 << B_SPR0) | (1 << B_SPR1));
  localparam logic [CNT_W-1:0] WR_MASK  = PRE_MASK | BIT_MASK;
  localparam logic [CNT_W-1:0] CFG_MASK = WR_MASK & ~CNT_W'((1 << B_FLAG) | (1 << B_IE));

  logic             ctrl_wr, mod_wr;
  logic [CNT_W-1:0] wd_m, ctrl_d;

  assign ctrl_wr  = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign mod_wr   = wr_en && (addr == ADDR_W'(OFS_MOD));
  assign wd_m     = wdata & WR_MASK;
  assign restart  = ctrl_wr && (((ctrl_q ^ wd_m) & CFG_MASK) != '0);
  assign ovw_load = mod_wr && ctrl_q[B_OVW];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d         = wd_m;
      ctrl_d[B_FLAG] = ctrl_q[B_FLAG] & ~wdata[B_FLAG];
    end
    if (mod_wr) ctrl_d[B_FLAG] = 1'b0;
    if (wrap)   ctrl_d[B_FLAG] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mod_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (mod_wr) mod_q <= wdata;
    end
  end
endmodule

// File: rtl/pit_prescale.sv
module pit_prescale #(
  parameter int unsigned PRE_W = 4,
  parameter int unsigned DIV_W = 1 << PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] term;

  // One tick every 2^(pre+1) cycles.
  assign span = {{DIV_W{1'b0}}, 1'b1} << (32'(pre) + 32'd1);
  assign term = DIV_W'(span - {{DIV_W{1'b0}}, 1'b1});
  assign tick = run && (div_q == term);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !run || tick) div_q <= '0;
    else                                 div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] restart_val,
  input  logic             ovw_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] wrap_val,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap
);
  assign wrap = tick && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        count_q <= '1;
    else if (restart)  count_q <= restart_val;
    else if (ovw_load) count_q <= load_val;
    else if (wrap)     count_q <= wrap_val;
    else if (tick)     count_q <= count_q - 1'b1;
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  localparam int unsigned DIV_W = 1 << PRE_W;

  logic [CNT_W-1:0] ctrl_q, mod_q, count_q;
  logic [CNT_W-1:0] cur_lim, new_lim, rd_mux;
  logic             restart, ovw_load, tick, wrap;

  pit_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wrap(wrap), .ctrl_q(ctrl_q), .mod_q(mod_q), .restart(restart),
    .ovw_load(ovw_load)
  );

  pit_prescale #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[B_RUN]), .clear(restart),
    .pre(ctrl_q[PRE_LSB +: PRE_W]), .tick(tick)
  );

  assign cur_lim = ctrl_q[B_RLD] ? mod_q : '1;
  assign new_lim = wdata[B_RLD]  ? mod_q : '1;

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .restart_val(new_lim), .ovw_load(ovw_load), .load_val(wdata),
    .wrap_val(cur_lim), .count_q(count_q), .wrap(wrap)
  );

  always_comb begin
    if (addr == ADDR_W'(OFS_CTRL))     rd_mux = ctrl_q;
    else if (addr == ADDR_W'(OFS_MOD)) rd_mux = mod_q;
    else if (addr == ADDR_W'(OFS_CNT)) rd_mux = count_q;
    else                               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq = ctrl_q[B_IE] & ctrl_q[B_FLAG];
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              irq,
  input logic [CNT_W-1:0]  ctrl_q,
  input logic [CNT_W-1:0]  mod_q,
  input logic [CNT_W-1:0]  count_q,
  input logic              restart,
  input logic              ovw_load,
  input logic              wrap
);
  logic mod_wr, other_wr;
  assign mod_wr   = wr_en && (addr == ADDR_W'(OFS_MOD));
  assign other_wr = wr_en && (addr != ADDR_W'(OFS_CTRL)) && (addr != ADDR_W'(OFS_MOD));

  p_hold_stopped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_RUN] && !restart && !ovw_load) |=> $stable(count_q));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !ovw_load && !wrap) |=>
      (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1));

  p_flag_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ctrl_q[B_FLAG]);

  p_free_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !restart && !ovw_load && !ctrl_q[B_RLD]) |=> (count_q == '1));

  p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));

  p_mod_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_wr && !wrap) |=> !ctrl_q[B_FLAG]);

  p_ignored_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr && !wrap) |=> ($stable(ctrl_q) && $stable(mod_q)));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .irq(irq),
  .ctrl_q(ctrl_q), .mod_q(mod_q), .count_q(count_q), .restart(restart),
  .ovw_load(ovw_load), .wrap(wrap)
);

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/1ps
module pit_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // Reference model built from the requirements.
  logic [15:0] m_ctrl, m_mod, m_cnt, m_div, m_rdata;

  function automatic logic [15:0] reg_value(input logic [2:0] a);
    case (a)
      3'd0:    return m_ctrl;
      3'd2:    return m_mod;
      3'd4:    return m_cnt;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] tick_term(input logic [3:0] p);
    logic [16:0] s;
    s = 17'd1 << (32'(p) + 32'd1);
    return 16'(s - 17'd1);
  endfunction

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (!rst_n) begin
      m_ctrl = 16'h0; m_mod = 16'h0; m_cnt = 16'hFFFF; m_div = 16'h0; m_rdata = 16'h0;
    end else begin
      logic run, tck, wrp, cw, mw, rs;
      logic [15:0] wdm, n_ctrl, n_cnt, n_mod, n_div;
      run = m_ctrl[0];
      tck = run && (m_div == tick_term(m_ctrl[11:8]));
      wrp = tck && (m_cnt == 16'h0);
      cw  = wr_en && addr == 3'd0;
      mw  = wr_en && addr == 3'd2;
      wdm = wdata & 16'h0F7B;
      rs  = cw && (((m_ctrl ^ wdm) & 16'h0F73) != 16'h0);
      if (rs)                    n_cnt = wdata[1] ? m_mod : 16'hFFFF;
      else if (mw && m_ctrl[4])  n_cnt = wdata;
      else if (wrp)              n_cnt = m_ctrl[1] ? m_mod : 16'hFFFF;
      else if (tck)              n_cnt = m_cnt - 16'd1;
      else                       n_cnt = m_cnt;
      n_div = (rs || !run || tck) ? 16'h0 : m_div + 16'd1;
      n_ctrl = m_ctrl;
      if (cw) begin n_ctrl = wdm; n_ctrl[2] = m_ctrl[2] & ~wdata[2]; end
      if (mw)  n_ctrl[2] = 1'b0;
      if (wrp) n_ctrl[2] = 1'b1;
      n_mod = mw ? wdata : m_mod;
      if (rd_en) m_rdata = reg_value(addr);
      m_ctrl = n_ctrl; m_cnt = n_cnt; m_div = n_div; m_mod = n_mod;
    end
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check({15'h0, irq}, {15'h0, m_ctrl[3] & m_ctrl[2]}, "R5 irq level");
      check(rdata, m_rdata, "R2 read data vs model");
    end
  end

  // Each task starts and ends at a falling edge.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int seed_v;
    logic [15:0] held;
    seed_v = $urandom(32'd424242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0); check(rdata, 16'h0000, "R1 ctrl after reset");
    rd(3'd2); check(rdata, 16'h0000, "R1 modulus after reset");
    rd(3'd4); check(rdata, 16'hFFFF, "R1 count after reset");
    check({15'h0, irq}, 16'h0, "R1 irq after reset");
    // R2 period: PRE=1 gives 4 cycles per tick, free-running
    wr(3'd0, 16'h0101);
    idle(7);
    rd(3'd4); check(rdata, 16'hFFFE, "R2 first tick after one period");
    rd(3'd4); check(rdata, 16'hFFFD, "R2 second tick");
    // R3 reload mode with modulus 5, PRE=0
    wr(3'd2, 16'h0005);
    wr(3'd0, 16'h0003);
    rd(3'd4); check(rdata, m_rdata, "R8 restart loads modulus");
    idle(30);
    rd(3'd0); check({15'h0, rdata[2]}, 16'h1, "R3 flag set at reload wrap");
    rd(3'd4); check({15'h0, rdata <= 16'h5}, 16'h1, "R3 count within modulus");
    // R5/R7 enable only toggles interrupt, count untouched
    wr(3'd0, 16'h000B);
    check({15'h0, irq}, 16'h1, "R5 irq with flag and enable");
    rd(3'd4); check(rdata, m_rdata, "R7 count undisturbed by enable write");
    // R6 write zero keeps flag, write one clears
    wr(3'd0, 16'h000B);
    rd(3'd0); check(rdata, m_rdata, "R6 flag kept on zero write");
    wr(3'd0, 16'h000F);
    rd(3'd0); check(rdata, m_rdata, "R6 flag cleared on one write");
    // R9 modulus write clears flag
    idle(30);
    wr(3'd2, 16'h0007);
    rd(3'd0); check(rdata, m_rdata, "R9 modulus write clears flag");
    // R10 overwrite loads at once
    wr(3'd0, 16'h0F1B);
    wr(3'd2, 16'h0123);
    rd(3'd4); check(rdata, 16'h0123, "R10 overwrite load");
    wr(3'd0, 16'h0F0B);
    wr(3'd2, 16'h0044);
    rd(3'd4); check(rdata, m_rdata, "R10 no load without overwrite");
    // R4 free-running wrap
    wr(3'd0, 16'h0019);
    wr(3'd2, 16'h0002);
    idle(8);
    rd(3'd4); check(rdata, m_rdata, "R4 free-running wrap value");
    // R12 stopped counter holds
    wr(3'd0, 16'h0000);
    rd(3'd4); held = rdata;
    idle(20);
    rd(3'd4); check(rdata, held, "R12 count holds while stopped");
    // R11 ignored writes and unknown offsets
    wr(3'd4, 16'h1234);
    wr(3'd6, 16'hFFFF);
    rd(3'd4); check(rdata, held, "R11 count write ignored");
    rd(3'd0); check(rdata, m_rdata, "R11 ctrl unchanged");
    rd(3'd6); check(rdata, 16'h0000, "R11 unknown offset reads zero");
    // Random traffic
    for (int n = 0; n < 20000; n++) begin
      int r;
      logic [15:0] d;
      r = $urandom % 100;
      if (r < 6) begin
        d = 16'($urandom);
        d[11:8] = ($urandom % 16 == 0) ? 4'($urandom) : 4'($urandom % 3);
        wr(3'd0, d);
      end else if (r < 12) begin
        wr(3'd2, 16'($urandom % 40));
      end else if (r < 30) begin
        rd(3'($urandom));
      end else if (r < 34) begin
        wr(3'($urandom) | 3'd1, 16'($urandom));
      end else begin
        @(negedge clk);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule